// File: doc/BRIEF.md
# Serial-Load Display Driver with Enable Framing and Blanking

This block takes a serial bit stream framed by an enable envelope and presents it as a parallel word of display drive outputs. While the enable line is high, each rising edge of the serial clock moves the word one place toward the top stage and puts the serial data bit into the bottom stage. When the enable line falls, the whole shift word is copied into a display register, which drives the outputs. No start bit is used. The top stage is also brought out as a serial output, so several of these blocks can be chained: hold their enables high together and they act as one long shift register.

A blank input turns every output off without touching the display register. When blank goes low again, the stored pattern returns unchanged, so a host can set brightness from the duty cycle of blank. The serial clock, enable, data and blank lines are sampled by the system clock `clk` and must already be synchronous to it. The output count is a parameter, normally 20 or 32. An output is on when it is 1 and off when it is 0.

The framing logic is a three-state machine. `ST_IDLE`: enable is low and no frame is open. `ST_SHIFT`: enable was high at the last sample. `ST_LOAD`: enable has just fallen, and the display register is written on the next edge. The transitions are:
- IDLE→SHIFT, when enable is high.
- SHIFT→SHIFT, when enable stays high.
- SHIFT→LOAD, when enable falls.
- LOAD→SHIFT, when enable is high again.
- LOAD→IDLE, when enable stays low.
- IDLE→IDLE, when enable stays low.

Top module: `vfd_serial_driver`

## Requirements
- R1: While `rst_n` is low, the shift stages, the display register, `seg_out` and `ser_dout` are all 0, and the machine is in `ST_IDLE`.
- R2: A serial clock rising edge is a `clk` edge that samples `ser_clk` high when the previous sample was low. If `ser_en` is also sampled high at that edge, stage 0 takes `ser_din` and stage i takes stage i-1.
- R3: When `ser_en` is sampled low, a serial clock rising edge changes neither the shift stages nor `ser_dout`.
- R4: Suppose the `clk` edge k samples `ser_en` low and the edge before it sampled `ser_en` high. Then at edge k+1 the display register takes the shift stages as they were after edge k, with stage i driving `seg_out[i]`.
- R5: The display register changes only at the edge that commits a load. It stays as it was while a new frame is being shifted in.
- R6: `ser_dout` always equals the top stage (index WIDTH-1). A bit therefore appears there after WIDTH shifts.
- R7: If `ser_dout` of one instance feeds `ser_din` of the next, and both share the serial clock and enable, the pair behaves as a single shift register. Its length is the sum of the two widths.
- R8: While `blank` is 1, every bit of `seg_out` is 0. The display register keeps its contents, and this includes loads committed during blanking.
- R9: While `blank` is 0, `seg_out` equals the display register in the same cycle. A pattern hidden by blanking therefore reappears as soon as `blank` drops.
- R10: If a shift occurs at the same edge that commits a load, the display register receives the pre-shift word, and the shift still takes effect in the stages.
- R11: `ST_LOAD` lasts exactly one cycle. The outputs still show the old pattern in the cycle after the fall is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; its rising edges shift the register |
| ser_en | input | 1 | Frame enable; high to shift, falling edge latches |
| ser_din | input | 1 | Serial data in, taken by stage 0 |
| blank | input | 1 | High forces all outputs off, keeping stored data |
| ser_dout | output | 1 | Top shift stage, for chaining to the next device |
| seg_out | output | WIDTH | Parallel display outputs, 1 = on |

## Verification
A behavioural queue model of a 32-stage and a 20-stage instance in a chain is compared with both devices on every clock. The stimulus uses several kinds of input pattern:
- Full 52-bit frames of irregular data. These distinguish a correct shift direction and chaining from a mirrored or truncated register.
- A short partial frame. This shows that the display holds while shifting and that the stages move by exactly one place per edge.
- Serial clock pulses with enable low, followed by an empty envelope. This exposes any shift that leaks through outside a frame.
- Blank pulses, including a load committed during blanking. These separate destroying the data from masking it.
- A shift placed on the exact load-commit edge. This catches a latch that takes the post-shift word.

// File: rtl/vfd_drv_pkg.sv
package vfd_drv_pkg;

    // Framing states of the enable envelope
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } frame_state_e;

endpackage

// File: rtl/vfd_edge_sense.sv
// Detects a low-to-high step of the serial clock as seen by the system clock.
module vfd_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    output logic clk_rise
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
        end
    end

    assign clk_rise = ser_clk & ~sclk_q;
endmodule

// File: rtl/vfd_frame_fsm.sv
// Tracks the enable envelope and issues shift and load strobes.
module vfd_frame_fsm
    import vfd_drv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_en,
    input  logic         clk_rise,
    output frame_state_e state_o,
    output logic         shift_pulse,
    output logic         load_pulse
);
    frame_state_e state_q;
    frame_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ser_en ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: state_d = ser_en ? ST_SHIFT : ST_LOAD;
            ST_LOAD:  state_d = ser_en ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        shift_pulse = clk_rise & ser_en;
        load_pulse  = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_pulse = 1'b0;
            ST_SHIFT: load_pulse = 1'b0;
            ST_LOAD:  load_pulse = 1'b1;
            default:  load_pulse = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/vfd_shift_chain.sv
// Serial-in shift register; data enters stage 0 and leaves at the top stage.
module vfd_shift_chain #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_pulse,
    input  logic             ser_din,
    output logic [WIDTH-1:0] stages,
    output logic             top_bit
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stage_nxt[i] = ser_din;
        end else begin : g_body
            assign stage_nxt[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift_pulse) begin
            stage_q <= stage_nxt;
        end
    end

    assign stages  = stage_q;
    assign top_bit = stage_q[TOP];
endmodule

// File: rtl/vfd_disp_latch.sv
// Display register with non-destructive blanking of the outputs.
module vfd_disp_latch #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_pulse,
    input  logic [WIDTH-1:0] stages,
    input  logic             blank,
    output logic [WIDTH-1:0] disp,
    output logic [WIDTH-1:0] seg_out
);
    logic [WIDTH-1:0] disp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q <= '0;
        end else if (load_pulse) begin
            disp_q <= stages;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        assign seg_out[i] = disp_q[i] & ~blank;
    end

    assign disp = disp_q;
endmodule

// File: rtl/vfd_serial_driver.sv
// Enable-framed serial display driver with cascade output and blanking.
module vfd_serial_driver
    import vfd_drv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_en,
    input  logic             ser_din,
    input  logic             blank,
    output logic             ser_dout,
    output logic [WIDTH-1:0] seg_out
);
    logic             clk_rise;
    logic             shift_pulse;
    logic             load_pulse;
    frame_state_e     state_q;
    logic [WIDTH-1:0] sh_q;
    logic [WIDTH-1:0] disp_q;

    vfd_edge_sense u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .clk_rise (clk_rise)
    );

    vfd_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_en      (ser_en),
        .clk_rise    (clk_rise),
        .state_o     (state_q),
        .shift_pulse (shift_pulse),
        .load_pulse  (load_pulse)
    );

    vfd_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_pulse (shift_pulse),
        .ser_din     (ser_din),
        .stages      (sh_q),
        .top_bit     (ser_dout)
    );

    vfd_disp_latch #(.WIDTH(WIDTH)) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_pulse (load_pulse),
        .stages     (sh_q),
        .blank      (blank),
        .disp       (disp_q),
        .seg_out    (seg_out)
    );
endmodule

// File: rtl/vfd_serial_driver_chk.sv
// Property checker bound to the driver top.
module vfd_serial_driver_chk
    import vfd_drv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_en,
    input logic             blank,
    input logic             ser_dout,
    input logic [WIDTH-1:0] seg_out,
    input logic [WIDTH-1:0] sh_q,
    input logic [WIDTH-1:0] disp_q,
    input frame_state_e     state
);
    // R3: no shift while enable is sampled low
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> ($stable(sh_q) && $stable(ser_dout)));

    // R4: load commit copies the shift stages
    p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (disp_q == $past(sh_q)));

    // R5: display holds while the frame stays open
    p_disp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ser_en) |=> $stable(disp_q));

    // R8: blanking darkens every output
    p_blank_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (seg_out == '0));

    // R9: unblanked outputs follow the display register
    p_unblank_show_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> (seg_out == disp_q));

    // R11: the load state never repeats
    p_load_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state != ST_LOAD));
endmodule

bind vfd_serial_driver vfd_serial_driver_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en   (ser_en),
    .blank    (blank),
    .ser_dout (ser_dout),
    .seg_out  (seg_out),
    .sh_q     (sh_q),
    .disp_q   (disp_q),
    .state    (state_q)
);

// File: tb/tb_vfd_serial_driver.sv
module tb_vfd_serial_driver;
    localparam int WA = 32;
    localparam int WB = 20;
    localparam int WT = WA + WB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_en = 1'b0;
    logic ser_din = 1'b0;
    logic blank = 1'b0;
    logic dout_a, dout_b;
    logic [WA-1:0] seg_a;
    logic [WB-1:0] seg_b;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vfd_serial_driver #(.WIDTH(WA)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_din(ser_din), .blank(blank), .ser_dout(dout_a), .seg_out(seg_a)
    );

    vfd_serial_driver #(.WIDTH(WB)) dut_b (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_din(dout_a), .blank(blank), .ser_dout(dout_b), .seg_out(seg_b)
    );

    // Behavioural reference: one queue for the whole chain
    bit chain_m[$];
    logic [WA-1:0] m_disp_a = '0;
    logic [WB-1:0] m_disp_b = '0;
    bit m_sclk_prev = 0, m_en_prev = 0, m_load_pend = 0;

    initial for (int i = 0; i < WT; i++) chain_m.push_back(1'b0);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WT; i++) chain_m[i] = 1'b0;
            m_disp_a = '0; m_disp_b = '0;
            m_sclk_prev = 0; m_en_prev = 0; m_load_pend = 0;
        end else begin
            if (m_load_pend) begin
                for (int i = 0; i < WA; i++) m_disp_a[i] = chain_m[i];
                for (int i = 0; i < WB; i++) m_disp_b[i] = chain_m[WA+i];
            end
            if (ser_clk && !m_sclk_prev && ser_en) begin
                chain_m.push_front(ser_din);
                void'(chain_m.pop_back());
            end
            m_load_pend = m_en_prev && !ser_en;
            m_sclk_prev = ser_clk;
            m_en_prev = ser_en;
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk({63'd0, dout_a}, {63'd0, chain_m[WA-1]}, "R6 dout_a model");
            chk({63'd0, dout_b}, {63'd0, chain_m[WT-1]}, "R7 dout_b model");
            chk({32'd0, seg_a}, {32'd0, blank ? '0 : m_disp_a}, "R4/R8/R9 seg_a model");
            chk({44'd0, seg_b}, {44'd0, blank ? 20'd0 : m_disp_b}, "R7/R8/R9 seg_b model");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [WT-1:0] w);
        for (int i = WT - 1; i >= 0; i--) begin
            ser_din = w[i];
            ser_clk = 1'b1; tick(2);
            ser_clk = 1'b0; tick(2);
        end
    endtask

    logic [WT-1:0] w1 = 52'hA_5C31_E96F_00D7;
    logic [WT-1:0] w2 = 52'h3_96E1_0FA5_C7B2;
    logic [WT-1:0] w3 = 52'hC_0A17_73E9_5D48;

    initial begin
        tick(3); #1;
        chk({32'd0, seg_a}, 64'd0, "R1 reset seg_a");
        chk({44'd0, seg_b}, 64'd0, "R1 reset seg_b");
        chk({63'd0, dout_a}, 64'd0, "R1 reset dout_a");
        rst_n = 1'b1;
        tick(2);

        // Full chained frame
        ser_en = 1'b1;
        send_frame(w1);
        #1;
        chk({63'd0, dout_a}, {63'd0, w1[WA-1]}, "R6 top stage after frame");
        chk({63'd0, dout_b}, {63'd0, w1[WT-1]}, "R7 chain top stage");
        chk({32'd0, seg_a}, 64'd0, "R5 no display change before fall");
        ser_en = 1'b0;
        tick(1); #1;
        chk({32'd0, seg_a}, 64'd0, "R11 old pattern during load state");
        tick(1); #1;
        chk({32'd0, seg_a}, {32'd0, w1[WA-1:0]}, "R4 latch on fall");
        chk({44'd0, seg_b}, {44'd0, w1[WT-1:WA]}, "R7 chained latch");

        // Partial frame: display holds, then shows shifted word
        ser_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            ser_din = 1'b1; ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
        end
        #1;
        chk({32'd0, seg_a}, {32'd0, w1[WA-1:0]}, "R5 hold during shifting");
        ser_en = 1'b0;
        tick(3); #1;
        chk({32'd0, seg_a}, {32'd0, w1[21:0], 10'h3FF}, "R2 shift by ten");
        chk({44'd0, seg_b}, {44'd0, w1[41:22]}, "R2 chain shift by ten");

        // Clocks with enable low are ignored
        for (int i = 0; i < 6; i++) begin
            ser_din = i[0]; ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
        end
        #1;
        chk({63'd0, dout_a}, {63'd0, w1[21]}, "R3 dout unchanged");
        ser_en = 1'b1; tick(2); ser_en = 1'b0; tick(3); #1;
        chk({32'd0, seg_a}, {32'd0, w1[21:0], 10'h3FF}, "R3 stages unchanged");

        // Blanking retains data, including a load during blanking
        blank = 1'b1; tick(1); #1;
        chk({32'd0, seg_a}, 64'd0, "R8 blank seg_a");
        chk({44'd0, seg_b}, 64'd0, "R8 blank seg_b");
        ser_en = 1'b1; send_frame(w2); ser_en = 1'b0; tick(3); #1;
        chk({32'd0, seg_a}, 64'd0, "R8 dark after load");
        blank = 1'b0; tick(1); #1;
        chk({32'd0, seg_a}, {32'd0, w2[WA-1:0]}, "R9 pattern returns");
        chk({44'd0, seg_b}, {44'd0, w2[WT-1:WA]}, "R9 chain pattern returns");
        blank = 1'b1; tick(2); blank = 1'b0; tick(1); #1;
        chk({32'd0, seg_a}, {32'd0, w2[WA-1:0]}, "R9 unchanged after pulse");

        // Shift on the load-commit edge
        ser_en = 1'b1; send_frame(w3);
        ser_en = 1'b0; tick(1);
        ser_en = 1'b1; ser_din = 1'b1; ser_clk = 1'b1; tick(1); #1;
        chk({32'd0, seg_a}, {32'd0, w3[WA-1:0]}, "R10 pre-shift word latched");
        ser_clk = 1'b0; tick(2); ser_en = 1'b0; tick(3); #1;
        chk({32'd0, seg_a}, {32'd0, w3[30:0], 1'b1}, "R10 shift kept");
        chk({44'd0, seg_b}, {44'd0, w3[50:31]}, "R10 chain shift kept");

        // Reset in mid operation
        rst_n = 1'b0; tick(1); #1;
        chk({32'd0, seg_a}, 64'd0, "R1 reset clears seg_a");
        chk({44'd0, seg_b}, 64'd0, "R1 reset clears seg_b");
        chk({63'd0, dout_a}, 64'd0, "R1 reset clears dout");
        rst_n = 1'b1; tick(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule